// File: doc/BRIEF.md
# Interrupt Pending and Enable Unit

This block keeps the per-cause interrupt-pending and interrupt-enable words for one RISC-V style hardware thread. Each cause at the user, supervisor and machine levels owns one bit. Peripherals or timer logic set and clear pending bits through a single request port. A clear-all strobe flushes every pending bit at once. Software sees both words through full-word CSR read and write ports.

Three global enable flags come from the status register, one per privilege level. Each flag unmasks the software, timer and external causes of its own level. The unit raises a registered "interrupt available" flag whenever some cause is pending, enabled and unmasked. Beside it, the unit reports the number of the lowest such cause, so that the trap logic knows which cause to take.

Top module: `irq_pe_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `ip_rdata`, `ie_rdata`, `irq_valid` and `irq_cause` read zero.
- R2: The cause bits are laid out as follows: software causes at 0 (user), 1 (supervisor) and 3 (machine); timer causes at 4, 5 and 7; external causes at 8, 9 and 11. Bits 2, 6 and 10 always read zero in both words: writes and posts aimed at them are dropped, and so are requests whose cause number is 12 or more.
- R3: When `req_valid` is high and `req_set` is 1, the pending bit named by `req_cause` is set one cycle later. The other pending bits keep their values.
- R4: When `req_valid` is high and `req_set` is 0, the pending bit named by `req_cause` is cleared one cycle later. The other pending bits keep their values.
- R5: A `clr_all` pulse zeroes the whole pending word one cycle later and leaves the enable word unchanged.
- R6: `ip_wr` loads `csr_wdata` into the pending word, and `ie_wr` loads it into the enable word. Both outputs show the new value after the next clock edge.
- R7: For the pending word, a CSR write in a cycle beats `clr_all`, and `clr_all` beats a post or clear request in that cycle. A request in the same cycle as an `ie_wr` still takes effect on the pending word.
- R8: `glb_m_en` unmasks causes 3, 7 and 11. `glb_s_en` unmasks causes 1, 5 and 9. `glb_u_en` unmasks causes 0, 4 and 8.
- R9: `irq_valid` is registered. After a clock edge it equals the OR over all bits of pending AND enable AND global mask, with each term taken from its value just before that edge.
- R10: While `irq_valid` is high, `irq_cause` is the lowest-numbered cause that was eligible in the same sampled cycle. While `irq_valid` is low, `irq_cause` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Post/clear request strobe |
| req_set | input | 1 | 1 = post (set), 0 = clear |
| req_cause | input | 4 | Cause number of the request |
| clr_all | input | 1 | Zero the whole pending word |
| ip_wr | input | 1 | CSR write of the pending word |
| ie_wr | input | 1 | CSR write of the enable word |
| csr_wdata | input | 12 | CSR write data for either word |
| ip_rdata | output | 12 | Current pending word |
| ie_rdata | output | 12 | Current enable word |
| glb_m_en | input | 1 | Machine-level global enable |
| glb_s_en | input | 1 | Supervisor-level global enable |
| glb_u_en | input | 1 | User-level global enable |
| irq_valid | output | 1 | Some cause can be taken |
| irq_cause | output | 4 | Lowest eligible cause number |

## Verification
Three sources can update the pending word in the same cycle: a CSR write, the clear-all strobe and a post or clear request. The bench sets up these collisions on purpose in directed steps and also lets them happen by chance during the random run. A reference model in the bench applies the precedence order and the reserved-bit mask, and the read-back value of the pending word in the following cycle is compared against that model. An enable-word write that lands together with a request is checked the same way: both changes must show up.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NCAUSE  = 12;
  localparam int CAUSE_W = 4;
  localparam int NLEVEL  = 4;   // cause slots per interrupt kind
  localparam int LVL_U   = 0;
  localparam int LVL_S   = 1;
  localparam int LVL_M   = 3;

  // Bits that exist: every slot whose level is user, supervisor or machine
  function automatic logic [NCAUSE-1:0] impl_mask();
    logic [NCAUSE-1:0] m;
    for (int i = 0; i < NCAUSE; i++) begin
      m[i] = ((i % NLEVEL) == LVL_U) || ((i % NLEVEL) == LVL_S) ||
             ((i % NLEVEL) == LVL_M);
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg
  import irq_pkg::*;
#(
  parameter int NC = NCAUSE,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [NC-1:0] wdata,
  input  logic          clr_all,
  input  logic          req_valid,
  input  logic          req_set,
  input  logic [CW-1:0] req_cause,
  output logic [NC-1:0] q
);
  localparam logic [NC-1:0] IMPL = impl_mask();

  logic [NC-1:0] req_oh;
  logic [NC-1:0] nxt;

  always_comb begin
    req_oh = '0;
    for (int i = 0; i < NC; i++) begin
      req_oh[i] = req_valid && (req_cause == CW'(i));
    end
  end

  always_comb begin
    if (wr)           nxt = wdata;
    else if (clr_all) nxt = '0;
    else if (req_set) nxt = q | req_oh;
    else              nxt = q & ~req_oh;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt & IMPL;
  end

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (q & ~IMPL) == '0);
  p_wr_wins_r7: assert property (@(posedge clk) disable iff (rst)
    wr |=> q == ($past(wdata) & IMPL));
  p_clr_all_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_all && !wr) |=> q == '0);
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg
  import irq_pkg::*;
#(
  parameter int NC = NCAUSE
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [NC-1:0] wdata,
  output logic [NC-1:0] q
);
  localparam logic [NC-1:0] IMPL = impl_mask();

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (wr) q <= wdata & IMPL;
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr |=> $stable(q));
endmodule

// File: rtl/irq_glob_mask.sv
module irq_glob_mask
  import irq_pkg::*;
#(
  parameter int NC = NCAUSE
) (
  input  logic          m_en,
  input  logic          s_en,
  input  logic          u_en,
  output logic [NC-1:0] mask
);
  for (genvar i = 0; i < NC; i++) begin : g_bit
    localparam int LVL = i % NLEVEL;
    if (LVL == LVL_M)      begin : g_m assign mask[i] = m_en; end
    else if (LVL == LVL_S) begin : g_s assign mask[i] = s_en; end
    else if (LVL == LVL_U) begin : g_u assign mask[i] = u_en; end
    else                   begin : g_r assign mask[i] = 1'b0; end
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NC = NCAUSE,
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NC-1:0] elig,
  output logic          valid,
  output logic [CW-1:0] cause
);
  logic [CW-1:0] low;

  // scan from the top so the lowest set bit is assigned last
  always_comb begin
    low = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (elig[i]) low = CW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cause <= '0;
    end else begin
      valid <= |elig;
      cause <= (|elig) ? low : '0;
    end
  end

  function automatic logic lowest_ok(logic [NC-1:0] e, logic [CW-1:0] c);
    logic [NC-1:0] below;
    below = (NC'(1) << c) - NC'(1);
    return e[c] && ((e & below) == '0);
  endfunction

  p_lowest_r10: assert property (@(posedge clk) disable iff (rst)
    valid |-> lowest_ok($past(elig), cause));
  p_idle_cause_r10: assert property (@(posedge clk) disable iff (rst)
    !valid |-> cause == '0);
endmodule

// File: rtl/irq_pe_unit.sv
module irq_pe_unit
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_set,
  input  logic [CAUSE_W-1:0] req_cause,
  input  logic               clr_all,
  input  logic               ip_wr,
  input  logic               ie_wr,
  input  logic [NCAUSE-1:0]  csr_wdata,
  output logic [NCAUSE-1:0]  ip_rdata,
  output logic [NCAUSE-1:0]  ie_rdata,
  input  logic               glb_m_en,
  input  logic               glb_s_en,
  input  logic               glb_u_en,
  output logic               irq_valid,
  output logic [CAUSE_W-1:0] irq_cause
);
  logic [NCAUSE-1:0] ip_q, ie_q, gmask, elig;

  irq_pend_reg #(.NC(NCAUSE), .CW(CAUSE_W)) u_pend (
    .clk(clk), .rst(rst), .wr(ip_wr), .wdata(csr_wdata),
    .clr_all(clr_all), .req_valid(req_valid), .req_set(req_set),
    .req_cause(req_cause), .q(ip_q)
  );

  irq_en_reg #(.NC(NCAUSE)) u_en (
    .clk(clk), .rst(rst), .wr(ie_wr), .wdata(csr_wdata), .q(ie_q)
  );

  irq_glob_mask #(.NC(NCAUSE)) u_mask (
    .m_en(glb_m_en), .s_en(glb_s_en), .u_en(glb_u_en), .mask(gmask)
  );

  assign elig = ip_q & ie_q & gmask;

  irq_pick #(.NC(NCAUSE), .CW(CAUSE_W)) u_pick (
    .clk(clk), .rst(rst), .elig(elig), .valid(irq_valid), .cause(irq_cause)
  );

  assign ip_rdata = ip_q;
  assign ie_rdata = ie_q;

  p_reset_r1: assert property (@(posedge clk)
    $past(rst) |-> (ip_q == '0 && ie_q == '0 && !irq_valid));
  p_valid_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
    irq_valid |-> $past(ie_q) != '0 && $past(ip_q) != '0);
endmodule

// File: tb/irq_pe_unit_test.sv
module irq_pe_unit_test;
  localparam logic [11:0] IMPL = 12'hBBB;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_set = 0, clr_all = 0, ip_wr = 0, ie_wr = 0;
  logic [3:0]  req_cause = '0;
  logic [11:0] csr_wdata = '0;
  logic        glb_m_en = 0, glb_s_en = 0, glb_u_en = 0;
  logic [11:0] ip_rdata, ie_rdata;
  logic        irq_valid;
  logic [3:0]  irq_cause;

  int total = 0, bad = 0;
  bit done = 0;
  logic [11:0] ip_m = '0, ie_m = '0;

  always #2 clk = ~clk;

  irq_pe_unit uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
    .req_cause(req_cause), .clr_all(clr_all), .ip_wr(ip_wr), .ie_wr(ie_wr),
    .csr_wdata(csr_wdata), .ip_rdata(ip_rdata), .ie_rdata(ie_rdata),
    .glb_m_en(glb_m_en), .glb_s_en(glb_s_en), .glb_u_en(glb_u_en),
    .irq_valid(irq_valid), .irq_cause(irq_cause)
  );

  function automatic logic [11:0] gmask(logic m, logic s, logic u);
    return {m, 1'b0, s, u, m, 1'b0, s, u, m, 1'b0, s, u};
  endfunction

  function automatic logic [3:0] lowest(logic [11:0] e);
    for (int i = 0; i < 12; i++) if (e[i]) return 4'(i);
    return 4'd0;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(logic rv, logic rs, logic [3:0] rc, logic ca,
                      logic iw, logic ew, logic [11:0] wd,
                      logic gm, logic gs, logic gu, string req);
    logic [11:0] el;
    logic [11:0] oh;
    req_valid = rv; req_set = rs; req_cause = rc; clr_all = ca;
    ip_wr = iw; ie_wr = ew; csr_wdata = wd;
    glb_m_en = gm; glb_s_en = gs; glb_u_en = gu;
    el = ip_m & ie_m & gmask(gm, gs, gu);
    oh = (rv && rc < 12) ? (12'd1 << rc) : 12'd0;
    if (iw)      ip_m = wd & IMPL;
    else if (ca) ip_m = '0;
    else if (rs) ip_m = (ip_m | oh) & IMPL;
    else         ip_m = ip_m & ~oh;
    if (ew) ie_m = wd & IMPL;
    @(negedge clk);
    chk(req, "ip", ip_rdata, ip_m);
    chk(req, "ie", ie_rdata, ie_m);
    chk({req, " R9"}, "valid", irq_valid, |el);
    chk({req, " R10"}, "cause", irq_cause, (|el) ? lowest(el) : 0);
  endtask

  task automatic idle(logic gm, logic gs, logic gu, string req);
    step(0, 0, 0, 0, 0, 0, 0, gm, gs, gu, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "ip reset", ip_rdata, 0);
    chk("R1", "ie reset", ie_rdata, 0);
    chk("R1", "valid reset", irq_valid, 0);
    rst = 1'b0;
    idle(1, 1, 1, "R1");

    // R6: full-word writes, reserved bits dropped (R2)
    step(0, 0, 0, 0, 0, 1, 12'hFFF, 1, 1, 1, "R6 R2");
    step(0, 0, 0, 0, 1, 0, 12'hFFF, 1, 1, 1, "R6 R2");
    idle(1, 1, 1, "R10");
    step(0, 0, 0, 0, 1, 0, 12'h000, 1, 1, 1, "R6");
    // R3: post reserved and out-of-range causes are ignored (R2)
    step(1, 1, 4'd2, 0, 0, 0, 0, 1, 1, 1, "R3 R2");
    step(1, 1, 4'd13, 0, 0, 0, 0, 1, 1, 1, "R3 R2");
    // R3 / R8: machine timer, only m enable
    step(1, 1, 4'd7, 0, 0, 0, 0, 1, 0, 0, "R3 R8");
    idle(1, 0, 0, "R8");
    idle(0, 1, 1, "R8");
    step(1, 1, 4'd5, 0, 0, 0, 0, 0, 1, 0, "R3 R8");
    idle(0, 1, 0, "R8");
    step(1, 1, 4'd8, 0, 0, 0, 0, 0, 0, 1, "R3 R8");
    idle(0, 0, 1, "R8");
    idle(1, 1, 1, "R10");
    // R4: clear lowest, next one wins
    step(1, 0, 4'd5, 0, 0, 0, 0, 1, 1, 1, "R4");
    idle(1, 1, 1, "R10");
    // R7: ip write beats post and clr_all; ie write with a request
    step(1, 1, 4'd0, 1, 1, 0, 12'h808, 1, 1, 1, "R7");
    step(1, 1, 4'd1, 0, 0, 1, 12'h0F0, 1, 1, 1, "R7");
    step(1, 1, 4'd3, 1, 0, 0, 0, 1, 1, 1, "R7 R5");
    // R5: clr_all keeps enables
    step(1, 1, 4'd9, 0, 0, 0, 0, 1, 1, 1, "R3");
    step(0, 0, 0, 1, 0, 0, 0, 1, 1, 1, "R5");
    idle(1, 1, 1, "R5");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0], r[1], 4'(r[5:2] % 14), r[7:6] == 2'b11, r[10:8] == 3'b000,
           r[13:11] == 3'b000, 12'($urandom), r[14], r[15], r[16], "R3 R4 R7");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule